// File: doc/BRIEF.md
# Bit-Sliced Conditioning ALU

This block is a purely combinational arithmetic logic unit of configurable width, assembled from identical one-bit slices joined by a ripple carry. A two-bit select picks one of four functions: bitwise AND, bitwise OR, complement of the second operand, or the full-adder sum of both operands plus an incoming carry.

Before the function is applied, each operand passes through a conditioning stage. Either operand can be forced to zero, and the first operand can then be complemented. With these three controls, the four basic functions also yield constants, the complement of A, increments, and subtraction. For example, complementing A and setting the carry input to 1 during a sum gives B minus A.

A surrounding datapath drives the operands and controls and samples the result within the same cycle. The block holds no state.

Top module: `sliced_alu`

## Requirements
- R1: With func_sel = 2'b00 the result is the bitwise AND of the conditioned operands.
- R2: With func_sel = 2'b01 the result is the bitwise OR of the conditioned operands.
- R3: With func_sel = 2'b10 the result is the bitwise complement of the conditioned B operand.
- R4: With func_sel = 2'b11, {carry_out, result} equals conditioned A plus conditioned B plus carry_in.
- R5: The select decoder drives exactly one of its four function enables for every select value.
- R6: When a_pass is 0, operand A is taken as all zeros before inversion and before any function.
- R7: When b_pass is 0, operand B is taken as all zeros for every function.
- R8: When a_flip is 1, the gated A operand is complemented. With a_pass = 0 this gives all ones.
- R9: For the three logical functions (func_sel other than 2'b11), carry_out is 0.
- R10: With a_pass = 1, b_pass = 1, a_flip = 1, func_sel = 2'b11 and carry_in = 1, the result equals B minus A modulo 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | First operand word |
| opnd_b | input | W | Second operand word |
| func_sel | input | 2 | Function select: 00 AND, 01 OR, 10 NOT B, 11 sum |
| a_pass | input | 1 | 1 passes A, 0 forces A to zero |
| b_pass | input | 1 | 1 passes B, 0 forces B to zero |
| a_flip | input | 1 | 1 complements the gated A |
| carry_in | input | 1 | Carry into slice 0 |
| result | output | W | Function output word |
| carry_out | output | 1 | Carry out of the top slice (sum only) |

## Verification
The block holds no state, so a fault shows at the ports as soon as the inputs settle. A broken decoder enable corrupts every bit of one function. A fault in the conditioning stage shows only for the control combinations that exercise it. A broken carry link shows only when a carry must travel through that bit position, so the operand patterns include long carry runs such as all ones plus one. Every select value is crossed with every conditioning setting and both carry inputs.

// File: rtl/alu_pkg.sv
// Package: shared select encoding for the sliced ALU.
// Assumes: a two-bit select, one enable per function.
package alu_pkg;
    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_SUM  = 2'b11
    } alu_fn_e;

    localparam int NUM_FN = 4;

    // One-hot enables, one per function.
    typedef struct packed {
        logic sum_en;
        logic notb_en;
        logic or_en;
        logic and_en;
    } fn_en_t;
endpackage

// File: rtl/alu_func_decode.sv
// Module: turns the two-bit select into four one-hot function enables.
// Assumes: select is always a known value; the output is one-hot.
module alu_func_decode
    import alu_pkg::*;
(
    input  logic [1:0] sel,
    output fn_en_t     en
);
    // Decode the select into exactly one active enable.
    always_comb begin
        en = '0;
        unique case (alu_fn_e'(sel))
            FN_AND:  en.and_en  = 1'b1;
            FN_OR:   en.or_en   = 1'b1;
            FN_NOTB: en.notb_en = 1'b1;
            FN_SUM:  en.sum_en  = 1'b1;
            default: en = '0;
        endcase
    end
endmodule

// File: rtl/alu_operand_cond.sv
// Module: conditions the operand words before the slices see them.
// Assumes: zero gating is applied first and A inversion after it.
module alu_operand_cond #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw_a,
    input  logic [W-1:0] raw_b,
    input  logic         a_pass,
    input  logic         b_pass,
    input  logic         a_flip,
    output logic [W-1:0] cond_a,
    output logic [W-1:0] cond_b
);
    logic [W-1:0] gated_a;

    // Gate both operands to zero, then optionally complement A.
    always_comb begin
        gated_a = raw_a & {W{a_pass}};
        cond_a  = gated_a ^ {W{a_flip}};
        cond_b  = raw_b & {W{b_pass}};
    end
endmodule

// File: rtl/alu_bit_slice.sv
// Module: one bit of the ALU, with its logic functions and a full adder.
// Assumes: exactly one enable is high; carry out is driven only for the sum.
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic   a,
    input  logic   b,
    input  logic   cin,
    input  fn_en_t en,
    output logic   y,
    output logic   cout
);
    logic half_s;
    logic half_c;
    logic full_s;
    logic full_c;

    // Two half adders form the full adder; the selected term drives the output.
    always_comb begin
        half_s = a ^ b;
        half_c = a & b;
        full_s = half_s ^ cin;
        full_c = half_c | (half_s & cin);
        y      = (en.and_en  & (a & b))
               | (en.or_en   & (a | b))
               | (en.notb_en & ~b)
               | (en.sum_en  & full_s);
        cout   = en.sum_en & full_c;
    end
endmodule

// File: rtl/sliced_alu.sv
// Module: top of the W-bit ALU, W identical slices joined by a ripple carry.
// Assumes: purely combinational; the result is valid once the carry has rippled.
module sliced_alu
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [1:0]   func_sel,
    input  logic         a_pass,
    input  logic         b_pass,
    input  logic         a_flip,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output logic         carry_out
);
    localparam int TOP = W - 1;

    fn_en_t       dec_en;
    logic [W-1:0] cond_a;
    logic [W-1:0] cond_b;
    logic [W:0]   chain;

    alu_func_decode u_dec (
        .sel (func_sel),
        .en  (dec_en)
    );

    alu_operand_cond #(.W(W)) u_cond (
        .raw_a  (opnd_a),
        .raw_b  (opnd_b),
        .a_pass (a_pass),
        .b_pass (b_pass),
        .a_flip (a_flip),
        .cond_a (cond_a),
        .cond_b (cond_b)
    );

    // Feed the external carry into slice 0.
    always_comb chain[0] = carry_in;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_bit_slice u_bit (
            .a    (cond_a[i]),
            .b    (cond_b[i]),
            .cin  (chain[i]),
            .en   (dec_en),
            .y    (result[i]),
            .cout (chain[i+1])
        );
    end

    // The carry out of the top slice is the ALU carry output.
    always_comb carry_out = chain[TOP+1];
endmodule

// File: rtl/sliced_alu_chk.sv
// Module: checker bound to sliced_alu; relates the ports to the select and controls.
// Assumes: combinational design, so immediate checks run on settled values.
module sliced_alu_chk
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [1:0]   func_sel,
    input logic         a_pass,
    input logic         b_pass,
    input logic         a_flip,
    input logic         carry_in,
    input logic [W-1:0] result,
    input logic         carry_out,
    input fn_en_t       dec_en
);
    logic [W-1:0] ca;
    logic [W-1:0] cb;
    logic [W:0]   wide_sum;

    // Checks on the settled combinational outputs.
    always_comb begin
        ca       = (a_pass ? opnd_a : '0) ^ (a_flip ? '1 : '0);
        cb       = b_pass ? opnd_b : '0;
        wide_sum = {1'b0, ca} + {1'b0, cb} + {{W{1'b0}}, carry_in};
        if (!$isunknown(func_sel)) begin
            a_r5_onehot_enable: assert ($countones(dec_en) == 1);
            if (func_sel != 2'b11) begin
                a_r9_no_logic_carry: assert (carry_out == 1'b0);
            end
            if (func_sel == 2'b11) begin
                a_r4_sum_word: assert ({carry_out, result} == wide_sum);
            end
            if (func_sel == 2'b10) begin
                a_r3_notb: assert (result == ~cb);
            end
            if (func_sel == 2'b00 && a_pass && b_pass && !a_flip) begin
                a_r1_plain_and: assert (result == (opnd_a & opnd_b));
            end
            if (func_sel == 2'b11 && a_pass && b_pass && a_flip && carry_in) begin
                a_r10_b_minus_a: assert (result == W'(opnd_b - opnd_a));
            end
        end
    end
endmodule

bind sliced_alu sliced_alu_chk #(.W(W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .func_sel  (func_sel),
    .a_pass    (a_pass),
    .b_pass    (b_pass),
    .a_flip    (a_flip),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .dec_en    (dec_en)
);

// File: tb/test_sliced_alu.sv
// Bench: a scoreboard for sliced_alu. The driver applies stimulus and queues
// the expected output; the monitor compares on the falling edge.
module test_sliced_alu;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] res;
        logic         co;
        string        tag;
        logic         logic_op;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [1:0]   func_sel = 2'b00;
    logic         a_pass = 1'b1;
    logic         b_pass = 1'b1;
    logic         a_flip = 1'b0;
    logic         carry_in = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;

    int   checks = 0;
    int   fails = 0;
    bit   done = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    sliced_alu #(.W(W)) i_sliced_alu (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .func_sel  (func_sel),
        .a_pass    (a_pass),
        .b_pass    (b_pass),
        .a_flip    (a_flip),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out)
    );

    // Drive one stimulus and queue its expected value, built from the requirements.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] f,
                         input logic pa, input logic pb, input logic fl, input logic ci);
        exp_t         e;
        logic [W-1:0] xa;
        logic [W-1:0] xb;
        logic [W:0]   s;
        @(posedge clk);
        #1;
        opnd_a = a; opnd_b = b; func_sel = f;
        a_pass = pa; b_pass = pb; a_flip = fl; carry_in = ci;
        xa = pa ? a : '0;                    // R6
        if (fl) xa = ~xa;                    // R8
        xb = pb ? b : '0;                    // R7
        s  = {1'b0, xa} + {1'b0, xb} + (W+1)'(ci);
        e.co = 1'b0;
        e.logic_op = (f != 2'b11);
        case (f)
            2'b00: begin e.res = xa & xb; e.tag = "R1"; end
            2'b01: begin e.res = xa | xb; e.tag = "R2"; end
            2'b10: begin e.res = ~xb;     e.tag = "R3"; end
            default: begin e.res = s[W-1:0]; e.co = s[W]; e.tag = "R4"; end
        endcase
        if (f == 2'b11 && pa && pb && fl && ci) e.tag = "R10";
        else if (!pa) e.tag = {e.tag, "/R6"};
        else if (!pb) e.tag = {e.tag, "/R7"};
        else if (fl)  e.tag = {e.tag, "/R8"};
        else          e.tag = {e.tag, "/R5"};
        sb.push_back(e);
    endtask

    // Monitor: pop the expected item and compare at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (result !== e.res) begin
                fails++;
                $display("FAIL %s result actual=%h expected=%h", e.tag, result, e.res);
            end
            checks++;
            if (carry_out !== e.co) begin
                fails++;
                $display("FAIL %s carry actual=%b expected=%b", e.logic_op ? "R9" : e.tag,
                         carry_out, e.co);
            end
        end
    end

    // Stimulus: reset-time zero check, then the full control sweep.
    initial begin
        logic [W-1:0] pa_list [6];
        logic [W-1:0] pb_list [6];
        pa_list = '{8'h00, 8'hFF, 8'h5A, 8'h01, 8'h80, 8'h3C};
        pb_list = '{8'h00, 8'h01, 8'hA5, 8'hFF, 8'h7F, 8'hC3};
        repeat (2) @(posedge clk);
        #1;
        checks++;   // R1: quiescent inputs give a zero result and no carry
        if (result !== '0 || carry_out !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state actual=%h/%b expected=00/0", result, carry_out);
        end
        rst_n = 1'b1;
        for (int f = 0; f < 4; f++)
            for (int c = 0; c < 16; c++)
                for (int k = 0; k < 6; k++)
                    drive(pa_list[k], pb_list[k], 2'(f), c[0], c[1], c[2], c[3]);
        for (int k = 0; k < 40; k++)   // R10: subtraction on a spread of operand pairs
            drive(8'(k * 37 + 11), 8'(k * 101 + 3), 2'b11, 1'b1, 1'b1, 1'b1, 1'b1);
        drive(8'hFF, 8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1);   // R4: full carry ripple
        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(5 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule